// File: doc/BRIEF.md
# Configurable Edge and Level Interrupt Detector

This block watches a bank of external input pins and turns selected conditions on them into interrupts. Each pin is first brought into the local clock domain by a two-stage synchronizer. A per-channel trigger selection then decides what counts as an event: a rising edge, a falling edge, any transition, a high level or a low level. Each event sets a sticky pending bit. Software clears that bit by writing a one to it.

The pending bits are gated by a per-channel enable, and the gated bits are ORed into a single interrupt line. A small register interface exposes this state. Software can read the pending bits before and after gating, and it can read the synchronized pin values directly. The block has no debounce function. Its register bus is assumed to run in the same clock domain as the block.

Top module: `edgelvl_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq_o` is low.
- R2: The input-data register at offset 0x1C returns the pins as seen through two synchronizing flops: a pin change made before clock edge k becomes readable after edge k+1 and not after edge k.
- R3: When bit n of the both-edge register (0x14) and of the mode register (0x10) are 0, bit n of the polarity register (0x18) selects the edge: 1 means a rising edge sets pending bit n, 0 means a falling edge sets it. The opposite edge does not set it.
- R4: A 1 in bit n of the both-edge register makes any transition of pin n set pending bit n. In that case the mode and polarity bits have no effect, and a steady level sets nothing.
- R5: A 1 in bit n of the mode register selects level triggering. With polarity 1 a high pin sets pending bit n, and with polarity 0 a low pin sets it. While the active level persists, a clear does not leave the bit at zero.
- R6: Pending bits, read at offset 0x04, stay set until a 1 is written to the same bit at offset 0x0C. Bits written as 0 leave their channel untouched.
- R7: If a clear and a new event hit the same channel in the same cycle, the pending bit stays set.
- R8: Offset 0x08 reads the pending bits ANDed with the enable register (0x00). `irq_o` is high exactly when that value is non-zero.
- R9: Writes to offsets 0x04, 0x08 and 0x1C have no effect, and offset 0x0C reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | NUM_CH | Write data, one bit per channel |
| bus_rdata | output | NUM_CH | Read data for `bus_addr`, combinational |
| pin_i | input | NUM_CH | External input pins, asynchronous |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight channels and two synchronizer stages. With eight channels, a single table pass can place each trigger encoding on a different channel, while the other channels must stay quiet. Two stages fix the event latency at three clock edges. This fixed latency is what makes it possible to land a clear write in exactly the cycle where a new event arrives. Level and edge encodings are each driven through both the active and the inactive transition, so an encoding that swaps polarity or ignores the both-edge override shows up as a wrong pending bit.

// File: rtl/irqd_pkg.sv
// Package: shared register offsets and trigger configuration type.
// Assumes a byte-addressed register space with one 4-byte slot per register.
package irqd_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_ENABLE = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_LEVEL  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_ANYEDG = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_POL    = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_DATA   = 5'h1C;

    // Per-channel trigger selection; any_edge dominates the other two.
    typedef struct packed {
        logic lvl;
        logic any_edge;
        logic pol;
    } trig_cfg_t;

endpackage

// File: rtl/irqd_sync.sv
// Module: synchronizer bank for the input pins.
// Each pin passes through STAGES flops. A further flop keeps the previous
// synchronized sample so that edges can be found by comparison.
// Assumes STAGES >= 2 and pins that are asynchronous to clk.
module irqd_sync #(
    parameter int NUM_CH = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] smp_o,
    output logic [NUM_CH-1:0] prev_o
);

    logic [NUM_CH-1:0] stage_q [STAGES];
    logic [NUM_CH-1:0] prev_q;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Later stages shift the sample down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    // Holds the synchronized sample from one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign smp_o  = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/irqd_chan.sv
// Module: trigger decode and sticky pending bit for one channel.
// Assumes smp/prev are the current and previous synchronized samples.
// An event in the same cycle as a clear keeps the pending bit set.
module irqd_chan
    import irqd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp,
    input  logic      prev,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      evt,
    output logic      pend
);

    logic rise;
    logic fall;
    logic pend_q;

    // Classifies the current sample pair against the trigger selection.
    always_comb begin
        rise = smp & ~prev;
        fall = ~smp & prev;
        if (cfg.any_edge)  evt = rise | fall;
        else if (cfg.lvl)  evt = cfg.pol ? smp : ~smp;
        else               evt = cfg.pol ? rise : fall;
    end

    // Pending bit: set by an event, dropped by a clear, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= evt | (pend_q & ~clr);
    end

    assign pend = pend_q;

endmodule

// File: rtl/irqd_regs.sv
// Module: register file and read multiplexer.
// Holds enable, level, any-edge and polarity registers, and turns a write
// to the clear offset into a one-cycle clear pulse. Reads are combinational.
// Assumes single-cycle write strobes on the block clock.
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] pend,
    input  logic [NUM_CH-1:0] smp,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] lvl_o,
    output logic [NUM_CH-1:0] any_o,
    output logic [NUM_CH-1:0] pol_o,
    output logic [NUM_CH-1:0] clr_o,
    output logic [NUM_CH-1:0] masked_o,
    output logic [NUM_CH-1:0] bus_rdata
);

    logic [NUM_CH-1:0] en_q, lvl_q, any_q, pol_q;

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            lvl_q <= '0;
            any_q <= '0;
            pol_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_ENABLE: en_q  <= bus_wdata;
                OFF_LEVEL:  lvl_q <= bus_wdata;
                OFF_ANYEDG: any_q <= bus_wdata;
                OFF_POL:    pol_q <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Clear pulse: only during a write to the clear offset.
    always_comb begin
        clr_o = (bus_wr && bus_addr == OFF_CLEAR) ? bus_wdata : '0;
    end

    assign masked_o = pend & en_q;

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            OFF_ENABLE: bus_rdata = en_q;
            OFF_RAW:    bus_rdata = pend;
            OFF_MASKED: bus_rdata = masked_o;
            OFF_LEVEL:  bus_rdata = lvl_q;
            OFF_ANYEDG: bus_rdata = any_q;
            OFF_POL:    bus_rdata = pol_q;
            OFF_DATA:   bus_rdata = smp;
            default:    bus_rdata = '0;
        endcase
    end

    assign en_o  = en_q;
    assign lvl_o = lvl_q;
    assign any_o = any_q;
    assign pol_o = pol_q;

endmodule

// File: rtl/edgelvl_irq_ctrl.sv
// Module: top of the edge/level interrupt detector.
// Chains the synchronizer, one trigger channel per pin and the register
// file, then ORs the enabled pending bits into irq_o.
// Assumes a register bus in the clk domain.
module edgelvl_irq_ctrl
    import irqd_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NUM_CH-1:0] bus_wdata,
    output logic [NUM_CH-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] pin_i,
    output logic              irq_o
);

    logic [NUM_CH-1:0] smp, prev, evt, raw_q, en_q, lvl, any_e, pol, clr_pulse, masked;

    irqd_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .smp_o  (smp),
        .prev_o (prev)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            trig_cfg_t cfg;
            assign cfg = '{lvl: lvl[c], any_edge: any_e[c], pol: pol[c]};
            irqd_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .smp   (smp[c]),
                .prev  (prev[c]),
                .cfg   (cfg),
                .clr   (clr_pulse[c]),
                .evt   (evt[c]),
                .pend  (raw_q[c])
            );
        end
    endgenerate

    irqd_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend      (raw_q),
        .smp       (smp),
        .en_o      (en_q),
        .lvl_o     (lvl),
        .any_o     (any_e),
        .pol_o     (pol),
        .clr_o     (clr_pulse),
        .masked_o  (masked),
        .bus_rdata (bus_rdata)
    );

    assign irq_o = |masked;

endmodule

// File: rtl/irqd_chk.sv
// Module: assertion checker bound into the detector top.
// Relates the clear pulses, events and pending bits across cycles.
module irqd_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] raw,
    input logic [NUM_CH-1:0] evt,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] clr,
    input logic              irq
);

    // R6
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((raw & $past(clr & ~evt)) == '0));

    // R7
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt)));

    // R6
    set_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & ~$past(evt)) == '0));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(raw & en)));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

bind edgelvl_irq_ctrl irqd_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_q),
    .evt   (evt),
    .en    (en_q),
    .clr   (clr_pulse),
    .irq   (irq_o)
);

// File: tb/test_edgelvl_irq_ctrl.sv
module test_edgelvl_irq_ctrl;

    localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08, A_CLR = 5'h0C;
    localparam logic [4:0] A_LVL = 5'h10, A_ANY = 5'h14, A_POL = 5'h18, A_DAT = 5'h1C;

    // Vector: {channel, {level, any_edge, pol}, {pin_a, pin_b}, {exp_a, exp_b}}
    localparam int NV = 10;
    localparam logic [9:0] VEC [NV] = '{
        {3'd0, 3'b001, 2'b01, 2'b01},  // R3 rising, 0->1
        {3'd1, 3'b001, 2'b10, 2'b00},  // R3 rising, 1->0
        {3'd2, 3'b000, 2'b10, 2'b01},  // R3 falling, 1->0
        {3'd3, 3'b000, 2'b01, 2'b00},  // R3 falling, 0->1
        {3'd4, 3'b110, 2'b01, 2'b01},  // R4 any edge over level-low
        {3'd5, 3'b011, 2'b10, 2'b01},  // R4 any edge, 1->0
        {3'd6, 3'b101, 2'b01, 2'b01},  // R5 high level
        {3'd7, 3'b101, 2'b10, 2'b11},  // R5 high level held through clear
        {3'd0, 3'b100, 2'b10, 2'b01},  // R5 low level
        {3'd1, 3'b100, 2'b01, 2'b11}   // R5 low level held through clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_i = '0;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    edgelvl_irq_ctrl i_edgelvl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), rv);
            chk("R1 register reset", rv, 8'h00);
        end
        chk("R1 irq reset", {7'b0, irq_o}, 8'h00);

        // R2 synchronizer latency on the data register
        @(negedge clk); pin_i = 8'hA5;
        @(negedge clk); rd(A_DAT, rv); chk("R2 data after one edge", rv, 8'h00);
        @(negedge clk); rd(A_DAT, rv); chk("R2 data after two edges", rv, 8'hA5);
        @(negedge clk); pin_i = 8'h00;
        idle(4);

        // R3 R4 R5 table walk
        for (int v = 0; v < NV; v++) begin
            logic [2:0] ch;
            logic [7:0] bitm;
            ch   = VEC[v][9:7];
            bitm = 8'h01 << ch;
            wr(A_LVL, VEC[v][6] ? bitm : 8'h00);
            wr(A_ANY, VEC[v][5] ? bitm : 8'h00);
            wr(A_POL, VEC[v][4] ? bitm : 8'h00);
            @(negedge clk); pin_i = VEC[v][3] ? bitm : 8'h00;
            idle(5);
            wr(A_CLR, 8'hFF);
            rd(A_RAW, rv);
            chk($sformatf("R3/R4/R5 vector %0d before change", v), rv & bitm, VEC[v][1] ? bitm : 8'h00);
            pin_i = VEC[v][2] ? bitm : 8'h00;
            idle(5);
            rd(A_RAW, rv);
            chk($sformatf("R3/R4/R5 vector %0d after change", v), rv & bitm, VEC[v][0] ? bitm : 8'h00);
        end

        // Common setup: channel 0 any-edge, others falling edge, all pins low
        wr(A_LVL, 8'h00); wr(A_ANY, 8'h01); wr(A_POL, 8'h00);
        @(negedge clk); pin_i = 8'h00;
        idle(5);
        wr(A_CLR, 8'hFF);

        // R6 sticky until cleared, zero bits untouched
        @(negedge clk); pin_i = 8'h01;
        idle(5);
        @(negedge clk); pin_i = 8'h00;
        idle(5);
        rd(A_RAW, rv); chk("R6 pending stays set", rv, 8'h01);
        wr(A_CLR, 8'hFE);
        rd(A_RAW, rv); chk("R6 zero bit in clear ignored", rv, 8'h01);

        // R9 writes to read-only offsets ignored, clear reads zero
        wr(A_RAW, 8'h00); wr(A_MSK, 8'h00); wr(A_DAT, 8'hFF);
        rd(A_RAW, rv); chk("R9 raw not writable", rv, 8'h01);
        rd(A_DAT, rv); chk("R9 data not writable", rv, 8'h00);
        rd(A_CLR, rv); chk("R9 clear reads zero", rv, 8'h00);

        // R8 masking and irq combine
        rd(A_MSK, rv); chk("R8 masked with enable off", rv, 8'h00);
        chk("R8 irq low with enable off", {7'b0, irq_o}, 8'h00);
        wr(A_EN, 8'h03);
        rd(A_EN, rv); chk("R8 enable readback", rv, 8'h03);
        rd(A_MSK, rv); chk("R8 masked with enable on", rv, 8'h01);
        chk("R8 irq high", {7'b0, irq_o}, 8'h01);
        wr(A_CLR, 8'h01);
        rd(A_RAW, rv); chk("R6 pending cleared", rv, 8'h00);
        chk("R8 irq low after clear", {7'b0, irq_o}, 8'h00);

        // R7 clear in the same cycle as a new event
        @(negedge clk); pin_i = 8'h01;
        @(negedge clk);
        wr(A_CLR, 8'h01);
        rd(A_RAW, rv); chk("R7 event wins over clear", rv, 8'h01);
        wr(A_CLR, 8'h01);
        rd(A_RAW, rv); chk("R7 later clear takes effect", rv, 8'h00);

        finish_run();
    end

endmodule